// File: doc/BRIEF.md
# Last-Level Cache Maintenance Sequencer

This block accepts maintenance requests for a last-level cache through a small register bus and turns each request into a series of per-line commands. The commands are write back, discard, or both. Software selects the command in a control register. For a range request it first programs the upper address and then writes the lower address, and that second write launches the walk. A whole-cache request is launched by writing any value to one of two trigger registers, and it sweeps every set and way index.

The cache arrays sit outside the block. They see a line-operation port on which each command stays presented until the array acknowledges it. While a walk runs, a busy flag in the control register reads 1, and software polls it until it reads 0. A disable bit turns every trigger into an empty operation. The line size is chosen by a pin: 128 or 64 bytes.

Top module: `llc_maint_ctrl`

## Requirements
- R1: After reset, all stored registers read 0, the busy flag reads 0 and `lop_valid` is low.
- R2: Register word addresses are: 0 control, 1 range upper address, 2 range lower address, 3 whole-cache discard trigger, 4 whole-cache write-back trigger. The control register has these fields: bit 0 disable, bit 6 invalidate mode, bits 11..9 region operation, and bit 8 the read-only busy flag. All other control bits read 0, and a write to bit 8 has no effect. Addresses 3 and 4 read 0.
- R3: A write to the lower-address register launches a range walk. A write to the upper-address register only stores the value and starts nothing.
- R4: A range walk issues one command per line, with `lop_whole` low and `lop_addr` equal to the line-aligned byte address. The walk runs in ascending order from the line holding the lower address to the line holding the upper address, both lines included. Address bits below the line size are ignored.
- R5: With `line_size_sel` at 0 a line is 128 bytes. With `line_size_sel` at 1 a line is 64 bytes. The value is taken when the walk is launched.
- R6: `lop_kind` uses bit 0 for write back and bit 1 for discard. A range walk with region operation 001 uses discard (2) when invalidate mode is 0 and both (3) when invalidate mode is 1. Every other region operation value uses write back (1).
- R7: A write to address 3 issues SETS*WAYS commands with `lop_whole` high and `lop_addr` equal to indices 0, 1, 2 and so on in ascending order. The command is discard, or both when invalidate mode is set. A write to address 4 does the same with write back.
- R8: Each command holds `lop_valid`, `lop_addr`, `lop_kind` and `lop_whole` steady until a cycle in which `lop_ack` is high, and it completes in that cycle.
- R9: The busy flag reads 1 from the cycle after a trigger write and stays 1 until the final acknowledge. It reads 0 in the cycle after that acknowledge.
- R10: While busy, writes to addresses 1 to 4 are ignored: nothing is stored and nothing is launched. Control writes while busy do not change the command of the walk in progress.
- R11: A trigger with the disable bit set issues no command and reads busy for exactly one cycle.
- R12: A range whose upper line lies below its lower line issues no command and reads busy for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write word address |
| reg_wdata | input | DW | Register write data |
| reg_raddr | input | 3 | Register read word address |
| reg_rdata | output | DW | Register read data (combinational) |
| line_size_sel | input | 1 | 0: 128-byte lines, 1: 64-byte lines |
| lop_valid | output | 1 | Line command presented |
| lop_kind | output | 2 | Bit 0 write back, bit 1 discard |
| lop_whole | output | 1 | 1: address is a set/way index, 0: byte address |
| lop_addr | output | AW | Line byte address or set/way index |
| lop_ack | input | 1 | Line command accepted by the cache |

## Verification
Errors in the walk's internal state show up at the line-operation port as soon as the corrupted command is acknowledged. A wrong line counter or shift gives a missing, repeated or misaligned address. A wrong stop test gives an extra or missing command and moves the edge where busy drops away from the cycle after the final acknowledge. A command latched at the wrong moment shows as a changed `lop_kind` right after a control write in the middle of a walk. A wrongly stored register shows on readback right after the busy walk ends.

// File: rtl/llc_maint_pkg.sv
package llc_maint_pkg;
   localparam int unsigned RA_W      = 3;
   localparam int unsigned CB_DIS    = 0;
   localparam int unsigned CB_IM     = 6;
   localparam int unsigned CB_BUSY   = 8;
   localparam int unsigned CB_ROP_LO = 9;
   localparam int unsigned ROP_W     = 3;

   localparam logic [RA_W-1:0] RA_CTRL  = 3'd0;
   localparam logic [RA_W-1:0] RA_HI    = 3'd1;
   localparam logic [RA_W-1:0] RA_LO    = 3'd2;
   localparam logic [RA_W-1:0] RA_WIPE  = 3'd3;
   localparam logic [RA_W-1:0] RA_DRAIN = 3'd4;

   localparam logic [ROP_W-1:0] ROP_DISCARD = 3'b001;

   typedef enum logic [1:0] {
      LOP_NONE    = 2'd0,
      LOP_CLEAN   = 2'd1,
      LOP_DISCARD = 2'd2,
      LOP_BOTH    = 2'd3
   } lop_kind_e;

   typedef enum logic [1:0] {
      W_IDLE  = 2'd0,
      W_RUN   = 2'd1,
      W_CLOSE = 2'd2
   } walk_state_e;

   function automatic lop_kind_e pick_kind(input logic discard_req, input logic im);
      if (!discard_req) return LOP_CLEAN;
      return im ? LOP_BOTH : LOP_DISCARD;
   endfunction
endpackage

// File: rtl/llc_maint_regs.sv
module llc_maint_regs
   import llc_maint_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [RA_W-1:0] wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [RA_W-1:0] rd_addr,
   output logic [DW-1:0]   rd_data,
   input  logic            busy,
   output logic            go,
   output logic            go_whole,
   output lop_kind_e       go_kind,
   output logic            go_off,
   output logic [AW-1:0]   go_lo,
   output logic [AW-1:0]   go_hi
);
   initial begin
      assert (DW >= AW) else $fatal(1, "data width below address width");
      assert (DW >= CB_ROP_LO + ROP_W) else $fatal(1, "data width too small for control");
   end

   logic             dis_q, im_q;
   logic [ROP_W-1:0] rop_q;
   logic [AW-1:0]    hi_q, lo_q;

   logic wr_ctrl, hit_hi, hit_lo, hit_wipe, hit_drain;

   assign wr_ctrl   = wr_en && (wr_addr == RA_CTRL);
   assign hit_hi    = wr_en && (wr_addr == RA_HI)    && !busy;
   assign hit_lo    = wr_en && (wr_addr == RA_LO)    && !busy;
   assign hit_wipe  = wr_en && (wr_addr == RA_WIPE)  && !busy;
   assign hit_drain = wr_en && (wr_addr == RA_DRAIN) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q <= 1'b0;
         im_q  <= 1'b0;
         rop_q <= '0;
         hi_q  <= '0;
         lo_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            dis_q <= wr_data[CB_DIS];
            im_q  <= wr_data[CB_IM];
            rop_q <= wr_data[CB_ROP_LO +: ROP_W];
         end
         if (hit_hi) hi_q <= wr_data[AW-1:0];
         if (hit_lo) lo_q <= wr_data[AW-1:0];
      end
   end

   assign go       = hit_lo || hit_wipe || hit_drain;
   assign go_whole = hit_wipe || hit_drain;
   assign go_off   = dis_q;
   assign go_lo    = wr_data[AW-1:0];
   assign go_hi    = hi_q;

   always_comb begin
      if (hit_lo)        go_kind = pick_kind(rop_q == ROP_DISCARD, im_q);
      else if (hit_wipe) go_kind = pick_kind(1'b1, im_q);
      else               go_kind = LOP_CLEAN;
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         RA_CTRL: begin
            rd_data[CB_DIS]               = dis_q;
            rd_data[CB_IM]                = im_q;
            rd_data[CB_BUSY]              = busy;
            rd_data[CB_ROP_LO +: ROP_W]   = rop_q;
         end
         RA_HI:   rd_data = DW'(hi_q);
         RA_LO:   rd_data = DW'(lo_q);
         default: rd_data = '0;
      endcase
   end

   assert_go_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> busy);

   assert_hi_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && wr_addr == RA_HI) |=> (hi_q == $past(hi_q)));

   assert_lo_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && wr_addr == RA_LO) |=> (lo_q == $past(lo_q)));
endmodule

// File: rtl/llc_maint_walker.sv
module llc_maint_walker
   import llc_maint_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned SETS      = 16,
   parameter int unsigned WAYS      = 4,
   parameter int unsigned LSZ_BIG   = 7,
   parameter int unsigned LSZ_SMALL = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          go_whole,
   input  lop_kind_e     go_kind,
   input  logic          go_off,
   input  logic [AW-1:0] go_lo,
   input  logic [AW-1:0] go_hi,
   input  logic          line_sel,
   input  logic          lop_ack,
   output logic          busy,
   output logic          lop_valid,
   output lop_kind_e     lop_kind,
   output logic          lop_whole,
   output logic [AW-1:0] lop_addr
);
   localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1;
   localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int unsigned SH_W  = $clog2(LSZ_BIG + 1);

   initial begin
      assert (SETS >= 2 && (SETS & (SETS - 1)) == 0) else $fatal(1, "SETS must be a power of two");
      assert (WAYS >= 1 && (WAYS & (WAYS - 1)) == 0) else $fatal(1, "WAYS must be a power of two");
      assert (AW >= SET_W + WAY_W) else $fatal(1, "address too narrow for index");
      assert (LSZ_SMALL < LSZ_BIG && LSZ_BIG < AW) else $fatal(1, "bad line size shifts");
   end

   walk_state_e     st_q;
   logic            whole_q;
   lop_kind_e       kind_q;
   logic [SH_W-1:0] sh_q;
   logic [AW-1:0]   cur_q, last_q;
   logic [SET_W-1:0] set_q;
   logic [WAY_W-1:0] way_q;

   logic [SH_W-1:0] go_sh;
   logic [AW-1:0]   lo_ln, hi_ln, whole_addr;
   logic            go_empty, set_last, way_last, step_last;

   assign go_sh    = line_sel ? SH_W'(LSZ_SMALL) : SH_W'(LSZ_BIG);
   assign lo_ln    = go_lo >> go_sh;
   assign hi_ln    = go_hi >> go_sh;
   assign go_empty = !go_whole && (hi_ln < lo_ln);
   assign set_last = (set_q == SET_W'(SETS - 1));

   generate
      if (WAYS == 1) begin : g_direct
         assign way_last   = 1'b1;
         assign whole_addr = AW'(set_q);
      end else begin : g_assoc
         assign way_last   = (way_q == WAY_W'(WAYS - 1));
         assign whole_addr = AW'({way_q, set_q});
      end
   endgenerate

   assign step_last = whole_q ? (set_last && way_last) : (cur_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= W_IDLE;
         whole_q <= 1'b0;
         kind_q  <= LOP_NONE;
         sh_q    <= '0;
         cur_q   <= '0;
         last_q  <= '0;
         set_q   <= '0;
         way_q   <= '0;
      end else begin
         case (st_q)
            W_IDLE: if (go) begin
               whole_q <= go_whole;
               kind_q  <= go_kind;
               sh_q    <= go_sh;
               cur_q   <= lo_ln;
               last_q  <= hi_ln;
               set_q   <= '0;
               way_q   <= '0;
               st_q    <= (go_off || go_empty) ? W_CLOSE : W_RUN;
            end
            W_RUN: if (lop_ack) begin
               if (step_last) begin
                  st_q <= W_IDLE;
               end else if (whole_q) begin
                  set_q <= set_q + 1'b1;
                  if (set_last) way_q <= way_q + 1'b1;
               end else begin
                  cur_q <= cur_q + 1'b1;
               end
            end
            default: st_q <= W_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != W_IDLE);
   assign lop_valid = (st_q == W_RUN);
   assign lop_kind  = lop_valid ? kind_q : LOP_NONE;
   assign lop_whole = lop_valid && whole_q;
   assign lop_addr  = whole_q ? whole_addr : (cur_q << sh_q);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lop_valid && !lop_ack) |=> (lop_valid && $stable(lop_addr) && $stable(lop_kind) && $stable(lop_whole)));

   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !lop_valid);

   assert_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lop_valid && !lop_whole) |-> (lop_addr[LSZ_SMALL-1:0] == '0));

   assert_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lop_valid && lop_ack) |=> (!lop_valid || (lop_addr > $past(lop_addr))));

   assert_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lop_valid |-> (lop_kind != LOP_NONE));

   assert_skip_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy && (go_off || go_empty)) |=> (busy && !lop_valid));
endmodule

// File: rtl/llc_maint_ctrl.sv
module llc_maint_ctrl
   import llc_maint_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned DW        = 32,
   parameter int unsigned SETS      = 16,
   parameter int unsigned WAYS      = 4,
   parameter int unsigned LSZ_BIG   = 7,
   parameter int unsigned LSZ_SMALL = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_waddr,
   input  logic [DW-1:0] reg_wdata,
   input  logic [2:0]    reg_raddr,
   output logic [DW-1:0] reg_rdata,
   input  logic          line_size_sel,
   output logic          lop_valid,
   output logic [1:0]    lop_kind,
   output logic          lop_whole,
   output logic [AW-1:0] lop_addr,
   input  logic          lop_ack
);
   logic          busy, go, go_whole, go_off;
   lop_kind_e     go_kind, kind_w;
   logic [AW-1:0] go_lo, go_hi;

   llc_maint_regs #(.AW(AW), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we),
      .wr_addr  (reg_waddr),
      .wr_data  (reg_wdata),
      .rd_addr  (reg_raddr),
      .rd_data  (reg_rdata),
      .busy     (busy),
      .go       (go),
      .go_whole (go_whole),
      .go_kind  (go_kind),
      .go_off   (go_off),
      .go_lo    (go_lo),
      .go_hi    (go_hi)
   );

   llc_maint_walker #(
      .AW(AW), .SETS(SETS), .WAYS(WAYS), .LSZ_BIG(LSZ_BIG), .LSZ_SMALL(LSZ_SMALL)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .go_whole  (go_whole),
      .go_kind   (go_kind),
      .go_off    (go_off),
      .go_lo     (go_lo),
      .go_hi     (go_hi),
      .line_sel  (line_size_sel),
      .lop_ack   (lop_ack),
      .busy      (busy),
      .lop_valid (lop_valid),
      .lop_kind  (kind_w),
      .lop_whole (lop_whole),
      .lop_addr  (lop_addr)
   );

   assign lop_kind = kind_w;
endmodule

// File: tb/llc_maint_ctrl_bench.sv
module llc_maint_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int NL = 64;
   localparam int RMAX = 256;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [2:0] reg_waddr = '0, reg_raddr = '0;
   logic [DW-1:0] reg_wdata = '0, reg_rdata;
   logic line_size_sel = 1'b0;
   logic lop_valid, lop_whole, lop_ack;
   logic [1:0] lop_kind;
   logic [AW-1:0] lop_addr;

   llc_maint_ctrl u_llc_maint_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .line_size_sel(line_size_sel), .lop_valid(lop_valid), .lop_kind(lop_kind),
      .lop_whole(lop_whole), .lop_addr(lop_addr), .lop_ack(lop_ack)
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   logic [AW-1:0] rec_addr [RMAX];
   logic [1:0]    rec_kind [RMAX];
   logic          rec_whole[RMAX];
   int rec_n = 0, last_ack_cyc = 0, hold_err = 0;
   logic [AW-1:0] prev_addr;
   logic [1:0]    prev_kind;
   bit prev_pend = 0;

   // Acknowledge side of the line-op port, with random wait states.
   initial begin
      int wait_n;
      wait_n = 0;
      lop_ack = 1'b0;
      forever begin
         @(negedge clk);
         if (prev_pend && lop_valid && (lop_addr != prev_addr || lop_kind != prev_kind))
            hold_err++;
         prev_pend = 0;
         if (lop_ack) begin
            lop_ack = 1'b0;
         end else if (lop_valid) begin
            if (wait_n == 0) begin
               if (rec_n < RMAX) begin
                  rec_addr[rec_n]  = lop_addr;
                  rec_kind[rec_n]  = lop_kind;
                  rec_whole[rec_n] = lop_whole;
               end
               rec_n++;
               last_ack_cyc = cyc;
               lop_ack = 1'b1;
               wait_n = $urandom % 3;
            end else begin
               wait_n--;
               prev_pend = 1;
               prev_addr = lop_addr;
               prev_kind = lop_kind;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
      reg_raddr = a;
      #1;
      v = reg_rdata;
   endtask

   function automatic logic [DW-1:0] ctrl_word(input int rop, input bit im, input bit dis);
      return (DW'(rop & 7) << 9) | (DW'(im) << 6) | DW'(dis);
   endfunction

   // Called right after the trigger write; returns cycles busy stayed set.
   task automatic watch_busy(input string req, output int busy_cycles);
      logic [DW-1:0] v;
      int k;
      rd(3'd0, v);
      check(v[8] == 1'b1, {req, " R9 busy after trigger"}, v[8], 1);
      k = 1;
      while (k < 4000) begin
         @(negedge clk);
         rd(3'd0, v);
         if (!v[8]) break;
         k++;
      end
      busy_cycles = k;
      if (rec_n > 0)
         check(cyc == last_ack_cyc + 1, {req, " R9 busy falls after last ack"}, cyc, last_ack_cyc + 1);
   endtask

   task automatic check_ops(input string req, input int exp_n, input bit whole,
                            input logic [AW-1:0] base, input int sh, input logic [1:0] kind);
      int bad;
      logic [AW-1:0] ea;
      check(rec_n == exp_n, {req, " op count"}, rec_n, exp_n);
      bad = 0;
      for (int i = 0; i < exp_n && i < rec_n && i < RMAX; i++) begin
         ea = whole ? AW'(i) : ((base + AW'(i)) << sh);
         if (rec_addr[i] != ea || rec_kind[i] != kind || rec_whole[i] != whole) begin
            if (bad == 0)
               $display("FAIL %s op %0d actual=%0h/%0d/%0d expected=%0h/%0d/%0d",
                        req, i, rec_addr[i], rec_kind[i], rec_whole[i], ea, kind, whole);
            bad++;
         end
      end
      n_checks++;
      if (bad != 0) n_fail++;
   endtask

   function automatic logic [1:0] range_kind(input int rop, input bit im);
      if ((rop & 7) == 1) return im ? 2'd3 : 2'd2;
      return 2'd1;
   endfunction

   task automatic do_range(input logic [AW-1:0] lo, input logic [AW-1:0] hi, input int rop,
                           input bit im, input bit dis, input bit sel, input string req);
      int sh, bc, n;
      logic [AW-1:0] lo_ln, hi_ln;
      line_size_sel = sel;
      wr(3'd0, ctrl_word(rop, im, dis));
      wr(3'd1, hi);
      rec_n = 0;
      wr(3'd2, lo);
      watch_busy(req, bc);
      sh = sel ? 6 : 7;
      lo_ln = lo >> sh;
      hi_ln = hi >> sh;
      n = (dis || hi_ln < lo_ln) ? 0 : int'(hi_ln - lo_ln) + 1;
      check_ops(req, n, 1'b0, lo_ln, sh, range_kind(rop, im));
      if (n == 0) check(bc == 1, {req, " single busy cycle"}, bc, 1);
   endtask

   task automatic do_whole(input bit drain, input bit im, input bit dis, input string req);
      int bc;
      wr(3'd0, ctrl_word(0, im, dis));
      rec_n = 0;
      wr(drain ? 3'd4 : 3'd3, 32'h1);
      watch_busy(req, bc);
      check_ops(req, dis ? 0 : NL, 1'b1, '0, 0, drain ? 2'd1 : (im ? 2'd3 : 2'd2));
      if (dis) check(bc == 1, {req, " single busy cycle"}, bc, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      int bc;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, v); check(v == 0, "R1 control after reset", v, 0);
      rd(3'd1, v); check(v == 0, "R1 upper after reset", v, 0);
      rd(3'd2, v); check(v == 0, "R1 lower after reset", v, 0);
      check(lop_valid == 1'b0, "R1 lop_valid after reset", lop_valid, 0);

      // R2 field layout
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); check(v == 32'h0000_0E41, "R2 control fields", v, 32'hE41);
      rd(3'd3, v); check(v == 0, "R2 trigger address reads 0", v, 0);
      wr(3'd0, 32'h0);

      // R3 upper write alone starts nothing
      rec_n = 0;
      wr(3'd1, 32'h0000_4000);
      repeat (3) @(negedge clk);
      rd(3'd0, v);
      check(v[8] == 1'b0 && rec_n == 0, "R3 upper write starts nothing", v[8], 0);
      rd(3'd1, v); check(v == 32'h4000, "R3 upper stored", v, 32'h4000);

      // R4 R5 R6 directed ranges
      do_range(32'h0000_1010, 32'h0000_11FF, 0, 0, 0, 0, "R4 R5 128B flush");
      do_range(32'h0000_1010, 32'h0000_11FF, 1, 0, 0, 1, "R5 64B discard R6");
      do_range(32'h0000_2000, 32'h0000_2000, 1, 1, 0, 0, "R6 single line both");
      do_range(32'h0000_2080, 32'h0000_2000, 1, 0, 0, 0, "R12 empty range");
      do_range(32'h0000_3000, 32'h0000_3400, 0, 0, 1, 1, "R11 disabled range");

      // R7 whole-cache
      do_whole(1'b0, 1'b0, 1'b0, "R7 whole discard");
      do_whole(1'b0, 1'b1, 1'b0, "R7 whole both");
      do_whole(1'b1, 1'b0, 1'b0, "R7 whole flush");
      do_whole(1'b0, 1'b0, 1'b1, "R11 disabled whole");

      // R10 writes while busy
      wr(3'd0, 32'h0);
      wr(3'd1, 32'h0000_0100);
      wr(3'd2, 32'h0000_0080);
      rd(3'd0, v);
      while (v[8]) begin @(negedge clk); rd(3'd0, v); end
      rec_n = 0;
      wr(3'd4, 32'h1);
      wr(3'd1, 32'h0000_5000);
      wr(3'd2, 32'h0000_6000);
      wr(3'd3, 32'h1);
      wr(3'd0, ctrl_word(1, 1'b1, 1'b0));
      watch_busy("R10 busy writes", bc);
      check_ops("R10 whole flush unchanged", NL, 1'b1, '0, 0, 2'd1);
      rd(3'd1, v); check(v == 32'h0100, "R10 upper kept", v, 32'h100);
      rd(3'd2, v); check(v == 32'h0080, "R10 lower kept", v, 32'h80);

      line_size_sel = 1'b1;
      wr(3'd0, ctrl_word(1, 1'b0, 1'b0));
      wr(3'd1, 32'h0000_0A00);
      rec_n = 0;
      wr(3'd2, 32'h0000_0800);
      wr(3'd0, ctrl_word(0, 1'b1, 1'b0));
      watch_busy("R10 ctrl while busy", bc);
      check_ops("R10 ctrl write keeps command", 9, 1'b0, 32'h20, 6, 2'd2);

      // R8 hold across wait states
      check(hold_err == 0, "R8 command held until ack", hold_err, 0);

      // Random ranges
      for (int it = 0; it < 24; it++) begin
         logic [AW-1:0] lo, hi;
         lo = $urandom & 32'h000F_FFFF;
         hi = lo + ($urandom % 1100) - 40;
         do_range(lo, hi, $urandom % 8, 1'($urandom), 1'($urandom % 8 == 0), 1'($urandom),
                  "R4 R6 random range");
      end
      check(hold_err == 0, "R8 command held (random)", hold_err, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule